// File: doc/BRIEF.md
# Synthesizer Configuration Serial Slave

This block is the two-wire serial configuration port of a frequency synthesizer. A host writes six byte-wide configuration registers over an I2C bus and reads back one status byte. The block samples SCL and SDA with a fast system clock, finds START and STOP conditions, and matches a 7-bit device address whose upper four bits are fixed and whose lower three come from pins. It then takes either a write (a sub-address followed by data bytes, with the register pointer advancing after each byte) or a read (no sub-address; one status byte).

The register contents are decoded into the fields the synthesizer core uses: the operating mode, the swallow count A, the main count B, the reference divide R, the calibrator controls, the charge-pump current select and the oscillator amplitude. Some fields are split across neighbouring registers, so a multi-byte write is the normal way to load a new channel. SDA is driven as an open-drain pull-down enable. Clock stretching and high-speed mode are not supported.

Top module: `synth_cfg_i2c`

## Requirements
- R1: The device answers the address {1100, pin2, pin1, pin0}; bit 0 of the address byte is R/W, with 1 meaning read. On a match, the block pulls SDA low during the 9th clock. On a mismatch it never drives SDA and ignores all traffic until the next START.
- R2: A write consists of the address byte with R/W=0, a sub-address byte and data bytes, all MSB first. A single data byte to sub-address n (0..5) loads register n, and each legal data byte is acknowledged.
- R3: Each further data byte goes to the next sub-address. Sub-address 0x00 followed by six bytes loads registers 0x00 to 0x05 in order.
- R4: Register 0x01 holds B[8:1]. Register 0x02 holds B[0] in bit 7, A[5:0] in bits 6..1 and R[8] in bit 0. Register 0x03 holds R[7:0].
- R5: Register 0x04 holds the calibrator reset in bit 7, the calibration start in bit 6 and the external-calibration select in bit 5. Bits 4..0 hold the calibration word, with word bit 0 in bit 4 and word bit 4 in bit 0. Register 0x05 holds amplitude bit 0 in bit 7 and amplitude bit 1 in bit 6, and charge-pump select bits 0, 1 and 2 in bits 5, 4 and 3. Bits 2..0 of register 0x05 have no effect.
- R6: An address byte with R/W=1 is acknowledged, and then the status byte is shifted out MSB first. Bit 7 is the bad-sub-address flag, bit 6 the calibration-busy input, bit 5 the lock input and bits 4..0 the internal calibration word input. A NACK from the master ends the read.
- R7: A sub-address above 0x05 is acknowledged and sets the bad-sub-address flag. Data bytes that follow it are not acknowledged and change no register. The next sub-address of 0x05 or below clears the flag.
- R8: A data byte whose pointer has advanced past 0x05 is not acknowledged and is discarded.
- R9: After reset every register reads 0x00, so the mode is power-down and all fields are zero, and SDA is released.
- R10: START and STOP are recognised only while SCL is high. A repeated START restarts address matching. A STOP in the middle of a byte discards that byte.
- R11: The mode output carries all 8 bits of register 0x00 unchanged (0 = power-down, 1..9 = oscillator and divider choices).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain) |
| dev_pins_i | input | 3 | Low three bits of the device address |
| cal_busy_i | input | 1 | Calibration-in-progress status |
| lock_i | input | 1 | PLL lock status |
| intcal_i | input | 5 | Internal calibration word status |
| mode_o | output | 8 | Operating mode |
| b_cnt_o | output | 9 | Main counter B |
| a_cnt_o | output | 6 | Swallow counter A |
| r_div_o | output | 9 | Reference divider R |
| cal_reset_o | output | 1 | Calibrator reset control |
| cal_start_o | output | 1 | Calibration start control |
| cal_ext_o | output | 1 | External calibration select |
| cal_word_o | output | 5 | Forced calibration word |
| cp_sel_o | output | 3 | Charge-pump current select |
| amp_o | output | 2 | Oscillator amplitude |

## Verification
The assertions check on every cycle that SDA is never pulled while the engine is idle. They also check that the pull only changes while SCL is low or at a START or STOP, that a START resets the byte engine, that a STOP releases the line, and that no register write targets an address beyond 0x05. Only the bench scenarios show that the fields come out with the right bit order, that auto-increment loads registers in sequence, that bad and overrun bytes are refused, and that a read returns the live status with the flag set and then cleared. The same holds for a mismatched address, a repeated START and a STOP mid-byte, each of which must leave the registers untouched.

// File: rtl/synth_cfg_pkg.sv
// Shared constants and types for the synthesizer configuration slave.
// Assumes the register file is byte wide with a small fixed register count.
package synth_cfg_pkg;
    localparam int          NREG       = 6;
    localparam int          REG_AW     = $clog2(NREG);
    localparam logic [3:0]  DEV_PREFIX = 4'b1100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_SUB,
        ST_WDAT,
        ST_RDAT
    } bus_st_t;
endpackage

// File: rtl/i2c_line_cond.sv
// Brings SCL and SDA into the clock domain and derives edges and bus events.
// Assumes SCL is slow enough that every level lasts several system clocks.
module i2c_line_cond #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_N-1:0] scl_q, sda_q;
    logic              scl_p, sda_p;

    // Synchronizer chains; both idle high like the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_N-2:0], scl_i};
            sda_q <= {sda_q[SYNC_N-2:0], sda_i};
            scl_p <= scl_q[SYNC_N-1];
            sda_p <= sda_q[SYNC_N-1];
        end
    end

    // Edge and START/STOP detection on the synchronized levels.
    always_comb begin
        scl_s     = scl_q[SYNC_N-1];
        sda_s     = sda_q[SYNC_N-1];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

    // R10: a bus event is only ever seen with SCL held high.
    a_r10_event_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> (scl_s && $past(scl_s)));
endmodule

// File: rtl/i2c_cfg_engine.sv
// Byte engine of the slave: address match, sub-address pointer, write
// strobes, acknowledge and status read-out. Assumes conditioned bus events.
module i2c_cfg_engine
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        dev_pins_i,
    input  logic [6:0]        stat_i,
    output logic              sda_pull_o,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    bus_st_t    state;
    logic [3:0] bitcnt;
    logic [7:0] shreg, txreg, ptr;
    logic       ack_ph, bad_sub, mack;
    logic       byte_done, ptr_ok;
    logic [7:0] stat_byte;

    // Shared decode of the end of a received byte.
    always_comb begin
        byte_done = scl_fall && (bitcnt == 4'd8) && !ack_ph && !start_det && !stop_det;
        ptr_ok    = ptr < 8'(NREG);
        stat_byte = {bad_sub, stat_i};
        wr_en     = byte_done && (state == ST_WDAT) && ptr_ok;
        wr_addr   = ptr[REG_AW-1:0];
        wr_data   = shreg;
    end

    // Protocol state machine; SDA is changed only on falling SCL.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; bitcnt <= '0; shreg <= '0; txreg <= '0;
            ptr <= '0; ack_ph <= 1'b0; bad_sub <= 1'b0; mack <= 1'b0;
            sda_pull_o <= 1'b0;
        end else if (start_det) begin
            state <= ST_DEV; bitcnt <= '0; ack_ph <= 1'b0; sda_pull_o <= 1'b0;
        end else if (stop_det) begin
            state <= ST_IDLE; bitcnt <= '0; ack_ph <= 1'b0; sda_pull_o <= 1'b0;
        end else if (ack_ph) begin
            if (scl_fall) begin
                ack_ph     <= 1'b0;
                bitcnt     <= '0;
                sda_pull_o <= (state == ST_RDAT) ? ~txreg[7] : 1'b0;
            end
        end else begin
            case (state)
                ST_DEV, ST_SUB, ST_WDAT: begin
                    if (scl_rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        if (state == ST_DEV) begin
                            if (shreg[7:1] == {DEV_PREFIX, dev_pins_i}) begin
                                ack_ph     <= 1'b1;
                                sda_pull_o <= 1'b1;
                                if (shreg[0]) begin
                                    state <= ST_RDAT;
                                    txreg <= stat_byte;
                                end else begin
                                    state <= ST_SUB;
                                end
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_SUB) begin
                            ptr        <= shreg;
                            bad_sub    <= shreg >= 8'(NREG);
                            ack_ph     <= 1'b1;
                            sda_pull_o <= 1'b1;
                            state      <= ST_WDAT;
                        end else begin
                            ack_ph     <= 1'b1;
                            sda_pull_o <= ptr_ok;
                            if (ptr_ok) ptr <= ptr + 8'd1;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise && bitcnt == 4'd8) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (bitcnt < 4'd7) begin
                            txreg      <= {txreg[6:0], 1'b0};
                            sda_pull_o <= ~txreg[6];
                            bitcnt     <= bitcnt + 4'd1;
                        end else if (bitcnt == 4'd7) begin
                            sda_pull_o <= 1'b0;
                            bitcnt     <= 4'd8;
                        end else if (mack) begin
                            txreg      <= stat_byte;
                            sda_pull_o <= ~stat_byte[7];
                            bitcnt     <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: an idle (unaddressed) slave never pulls the line.
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_o);
    // R10: SDA from the slave never moves while SCL stays high, except at bus events.
    a_r10_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_pull_o));
    // R10: a START restarts address matching from the first bit.
    a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV && bitcnt == 4'd0 && !sda_pull_o));
    // R10: a STOP releases the line.
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_pull_o));
endmodule

// File: rtl/cfg_regbank.sv
// Six configuration bytes and the field decode the synthesizer core reads.
// Assumes writes arrive as single-cycle strobes with an in-range address.
module cfg_regbank
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        mode_o,
    output logic [8:0]        b_cnt_o,
    output logic [5:0]        a_cnt_o,
    output logic [8:0]        r_div_o,
    output logic              cal_reset_o,
    output logic              cal_start_o,
    output logic              cal_ext_o,
    output logic [4:0]        cal_word_o,
    output logic [2:0]        cp_sel_o,
    output logic [1:0]        amp_o
);
    logic [7:0] img [NREG];

    // Register storage, cleared to the power-down default on reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                img[i] <= 8'h00;
            else if (wr_en && wr_addr == REG_AW'(i))
                img[i] <= wr_data;
        end
    end

    // Field decode; several fields are spread or bit-reversed across bytes.
    always_comb begin
        mode_o      = img[0];
        b_cnt_o     = {img[1], img[2][7]};
        a_cnt_o     = img[2][6:1];
        r_div_o     = {img[2][0], img[3]};
        cal_reset_o = img[4][7];
        cal_start_o = img[4][6];
        cal_ext_o   = img[4][5];
        for (int k = 0; k < 5; k++) cal_word_o[k] = img[4][4-k];
        amp_o       = {img[5][6], img[5][7]};
        for (int k = 0; k < 3; k++) cp_sel_o[k] = img[5][5-k];
    end

    // R8: the engine never strobes a register beyond the map.
    a_r8_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < REG_AW'(NREG)));
    // R9: the cycle after reset, the mode is power-down and B is zero.
    a_r9_reset_default: assert property (@(posedge clk)
        $past(!rst_n) |-> (mode_o == 8'h00 && b_cnt_o == 9'd0));
endmodule

// File: rtl/synth_cfg_i2c.sv
// Top of the synthesizer configuration slave: line conditioning, byte
// engine and register bank. Assumes SDA is open-drain outside the block.
module synth_cfg_i2c
    import synth_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] dev_pins_i,
    input  logic       cal_busy_i,
    input  logic       lock_i,
    input  logic [4:0] intcal_i,
    output logic [7:0] mode_o,
    output logic [8:0] b_cnt_o,
    output logic [5:0] a_cnt_o,
    output logic [8:0] r_div_o,
    output logic       cal_reset_o,
    output logic       cal_start_o,
    output logic       cal_ext_o,
    output logic [4:0] cal_word_o,
    output logic [2:0] cp_sel_o,
    output logic [1:0] amp_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [REG_AW-1:0] wr_addr;
    logic [7:0]        wr_data;

    i2c_line_cond #(.SYNC_N(2)) line_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_cfg_engine eng_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .dev_pins_i(dev_pins_i), .stat_i({cal_busy_i, lock_i, intcal_i}),
        .sda_pull_o(sda_pull_o), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    cfg_regbank regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode_o(mode_o), .b_cnt_o(b_cnt_o), .a_cnt_o(a_cnt_o), .r_div_o(r_div_o),
        .cal_reset_o(cal_reset_o), .cal_start_o(cal_start_o), .cal_ext_o(cal_ext_o),
        .cal_word_o(cal_word_o), .cp_sel_o(cp_sel_o), .amp_o(amp_o)
    );
endmodule

// File: tb/synth_cfg_i2c_tb_top.sv
// Self-checking bench: table-driven single writes, then directed cases.
module synth_cfg_i2c_tb_top;
    localparam int Q = 10;  // system clocks per quarter SCL period
    localparam logic [2:0] PINS = 3'b101;
    localparam logic [7:0] AW = {4'b1100, PINS, 1'b0};
    localparam logic [7:0] AR = {4'b1100, PINS, 1'b1};
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        16'h00_07, 16'h01_A5, 16'h02_D3, 16'h03_3C,
        16'h04_6A, 16'h05_AF, 16'h02_2C, 16'h00_FF
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_pull, sda_bus;
    logic cal_busy = 1'b0, lock = 1'b0;
    logic [4:0] intcal = '0;
    logic [7:0] mode; logic [8:0] b_cnt, r_div; logic [5:0] a_cnt;
    logic cal_reset, cal_start, cal_ext; logic [4:0] cal_word;
    logic [2:0] cp_sel; logic [1:0] amp;
    logic [7:0] img [6];
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull;

    synth_cfg_i2c dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_pull_o(sda_pull),
        .dev_pins_i(PINS), .cal_busy_i(cal_busy), .lock_i(lock), .intcal_i(intcal),
        .mode_o(mode), .b_cnt_o(b_cnt), .a_cnt_o(a_cnt), .r_div_o(r_div),
        .cal_reset_o(cal_reset), .cal_start_o(cal_start), .cal_ext_o(cal_ext),
        .cal_word_o(cal_word), .cp_sel_o(cp_sel), .amp_o(amp)
    );

    task automatic wq(int n); repeat (n) @(negedge clk); endtask

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [44:0] model();
        logic [4:0] cw; logic [2:0] cp;
        cw = {img[4][0], img[4][1], img[4][2], img[4][3], img[4][4]};
        cp = {img[5][3], img[5][4], img[5][5]};
        return {img[0], img[1], img[2][7], img[2][6:1], img[2][0], img[3],
                img[4][7], img[4][6], img[4][5], cw, cp, img[5][6], img[5][7]};
    endfunction

    function automatic logic [44:0] outs();
        return {mode, b_cnt, a_cnt, r_div, cal_reset, cal_start, cal_ext, cal_word, cp_sel, amp};
    endfunction

    task automatic start_c();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic stop_c();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
        end
    endtask

    task automatic send_byte(logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        ack = ~sda_bus;
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        for (int i = 7; i >= 0; i--) begin
            wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1;
        wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q); m_sda = 1'b1;
    endtask

    // Full write transaction; returns the AND of all data-byte acks.
    task automatic wr_seq(logic [7:0] sub, logic [7:0] d [], output bit all_ack, output bit addr_ack);
        bit a;
        start_c(); send_byte(AW, addr_ack); send_byte(sub, a);
        all_ack = 1;
        foreach (d[i]) begin send_byte(d[i], a); all_ack &= a; end
        stop_c(); wq(Q);
    endtask

    task automatic rd_status(output logic [7:0] s, output bit addr_ack);
        start_c(); send_byte(AR, addr_ack); recv_byte(s, 1'b0); stop_c(); wq(Q);
    endtask

    initial begin
        bit ack, aack; logic [7:0] s; logic [7:0] d [];
        for (int i = 0; i < 6; i++) img[i] = 8'h00;
        wq(5); rst_n = 1'b1; wq(5);
        // R9: reset defaults and released line
        check(outs() == model() && !sda_pull, "R9 reset", {19'd0, outs()}, {19'd0, model()});

        // Table: single-byte writes, each checked at the decoded outputs
        for (int v = 0; v < NV; v++) begin
            d = new[1]; d[0] = VEC[v][7:0];
            wr_seq(VEC[v][15:8], d, ack, aack);
            img[VEC[v][15:8]] = VEC[v][7:0];
            check(aack && ack, "R1 R2 ack", {62'd0, aack, ack}, 64'd3);
            check(outs() == model(), "R2 R4 R5 R11 fields", {19'd0, outs()}, {19'd0, model()});
        end

        // R3: sub-address 0 with six bytes loads the whole map
        d = new[6]; d = '{8'h09, 8'h3E, 8'h81, 8'hC5, 8'h93, 8'h54};
        wr_seq(8'h00, d, ack, aack);
        for (int i = 0; i < 6; i++) img[i] = d[i];
        check(ack, "R3 burst ack", {63'd0, ack}, 64'd1);
        check(outs() == model(), "R3 burst fields", {19'd0, outs()}, {19'd0, model()});

        // R1: wrong pin bits, then wrong prefix - no ack, nothing changes
        start_c(); send_byte(8'hC4, ack); send_byte(8'h00, aack); send_byte(8'h55, aack); stop_c(); wq(Q);
        check(!ack && outs() == model(), "R1 pin mismatch", {18'd0, ack, outs()}, {19'd0, model()});
        start_c(); send_byte({4'b0100, PINS, 1'b0}, ack); send_byte(8'h01, aack); send_byte(8'h77, aack); stop_c(); wq(Q);
        check(!ack && outs() == model(), "R1 prefix mismatch", {18'd0, ack, outs()}, {19'd0, model()});

        // R6: status read with live inputs
        cal_busy = 1'b1; lock = 1'b1; intcal = 5'b10110;
        rd_status(s, aack);
        check(aack && s == 8'h76, "R6 status read", {55'd0, aack, s}, {55'd1, 8'h76});

        // R7: bad sub-address - data nacked, flag set, registers kept
        d = new[1]; d[0] = 8'hEE;
        wr_seq(8'h09, d, ack, aack);
        check(!ack && outs() == model(), "R7 bad sub data refused", {18'd0, ack, outs()}, {19'd0, model()});
        cal_busy = 1'b0; lock = 1'b0; intcal = 5'b00011;
        rd_status(s, aack);
        check(s == 8'h83, "R7 flag set", {56'd0, s}, {56'd0, 8'h83});
        d[0] = 8'h12;
        wr_seq(8'h03, d, ack, aack); img[3] = 8'h12;
        rd_status(s, aack);
        check(s == 8'h03, "R7 flag cleared", {56'd0, s}, {56'd0, 8'h03});

        // R8: auto-increment from 0x04 - third byte overruns and is refused
        start_c(); send_byte(AW, aack); send_byte(8'h04, ack);
        send_byte(8'hA0, ack); check(ack, "R8 byte to 0x04 acked", {63'd0, ack}, 64'd1);
        send_byte(8'h28, ack); check(ack, "R8 byte to 0x05 acked", {63'd0, ack}, 64'd1);
        send_byte(8'hFF, ack); check(!ack, "R8 overrun nacked", {63'd0, ack}, 64'd0);
        stop_c(); wq(Q); img[4] = 8'hA0; img[5] = 8'h28;
        check(outs() == model(), "R8 overrun discarded", {19'd0, outs()}, {19'd0, model()});

        // R10: STOP after four bits of a data byte discards it
        start_c(); send_byte(AW, aack); send_byte(8'h01, ack); send_bits(8'hF0, 4); stop_c(); wq(Q);
        check(outs() == model(), "R10 partial byte dropped", {19'd0, outs()}, {19'd0, model()});

        // R10: repeated START switches to a read mid-transaction
        lock = 1'b1; intcal = 5'b01001;
        start_c(); send_byte(AW, aack); send_byte(8'h00, ack);
        start_c(); send_byte(AR, aack); recv_byte(s, 1'b0); stop_c(); wq(Q);
        check(aack && s == 8'h29, "R10 repeated start read", {55'd0, aack, s}, {55'd1, 8'h29});
        check(outs() == model(), "R10 no write on restart", {19'd0, outs()}, {19'd0, model()});

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule